// File: doc/BRIEF.md
# Codec Serial Audio Link Port

This block connects to an external codec that owns the timing of a bidirectional serial audio link. The codec drives the bit clock and a frame sync whose high half carries the left channel and whose low half carries the right channel. Each half lasts 32 bit clocks. The block returns one stereo playback pair per frame on its primary output. From the primary input it collects two independent 16-bit stereo streams: the codec's converter samples and its returned playback mix. For extra speakers it also produces an auxiliary left/right clock and two right-justified auxiliary data lines, all timed from the opposite bit-clock edge.

On the system side every stream runs through a 16-deep FIFO. Each FIFO entry holds one stereo pair, left in the upper half. Three playback FIFOs (primary, auxiliary A, auxiliary B) take writes through a valid/ready handshake. Two capture FIFOs (converter samples, returned playback) are drained through valid/ready as well. All link signals are oversampled on the system clock, so the block works in one clock domain. Sticky flags report playback underruns and capture overruns.

Top module: `codec_link_port`

## Requirements
- R1: While `en` is low the port ignores the link and clears its state. The outputs `sdout`, `aux_lrclk`, `aux_sdo_a` and `aux_sdo_b` are 0, both flag vectors are 0, every FIFO is emptied, `play_ready` is 0 and `cap_valid` is 0.
- R2: After `en` rises, nothing is captured and `sdout` stays 0 until the port samples `fsync` on a falling `sclk` edge and sees it change from 0 to 1. That bit is bit 0 of the first frame, and this first frame is captured in full.
- R3: Bit p of a frame (0..63) on `sdout` is launched after the rising `sclk` edge that starts the bit. For q = p mod 32, bits with q < 16 carry sample bit 15-q, MSB first: the left word (entry bits 31:16) when p < 32, the right word (entry bits 15:0) otherwise. Bits with q >= 16 are 0.
- R4: The first frame after alignment sends zeros on `sdout`. Each later frame sends the next entry of playback stream 0.
- R5: At the falling `sclk` edge in bit p, the port drives `aux_lrclk` to 1 for p < 32 and to 0 otherwise. At the same edge each auxiliary line drives 0 for q < 16 and sample bit 31-q for q >= 16, so the data is right-justified and MSB first. Auxiliary A takes stream 1 and auxiliary B takes stream 2, one entry per frame starting with the first frame.
- R6: `sdin` is sampled on falling `sclk` edges. In each half-frame the first 16 bits form a converter sample and the last 16 bits form a returned playback sample, both MSB first. Capture stream 0 receives {left, right} converter pairs and capture stream 1 receives returned pairs, one entry per frame.
- R7: When a playback FIFO is empty at its frame boundary, that stream outputs zeros for the frame and sets its bit in `underrun` (bit index = stream), which stays set while enabled.
- R8: When a capture FIFO is full as a pair completes, the pair is dropped, the stored entries are unchanged, and the stream's bit in `overrun` is set and stays set while enabled.
- R9: `play_ready[s]` is 0 once stream s holds 16 entries. `cap_valid[c]` is 1 while capture stream c is non-empty, and the head entry is removed only in a cycle where `cap_ready[c]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the link |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Port enable; low flushes and realigns |
| sclk | input | 1 | Bit clock from codec |
| fsync | input | 1 | Frame sync from codec, high = left half |
| sdin | input | 1 | Primary serial input |
| sdout | output | 1 | Primary serial output |
| aux_lrclk | output | 1 | Auxiliary left/right clock |
| aux_sdo_a | output | 1 | Auxiliary serial output A |
| aux_sdo_b | output | 1 | Auxiliary serial output B |
| play_valid | input | 3 | Playback write strobes, one per stream |
| play_data | input | 3*2*DW | Playback pairs, stream s at bits s*2*DW upward |
| play_ready | output | 3 | Playback FIFO can accept |
| cap_valid | output | 2 | Capture FIFO holds data |
| cap_data | output | 2*2*DW | Capture head pairs, stream c at bits c*2*DW upward |
| cap_ready | input | 2 | Capture read strobes |
| underrun | output | 3 | Sticky playback underrun flags |
| overrun | output | 2 | Sticky capture overrun flags |

## Verification
The edge-timing properties assume each `sclk` level lasts at least four system clocks. Under that assumption a primary output change can only appear while `sclk` is high and an auxiliary change only while it is low. The bench acts as the codec and keeps each level for eight system clocks. It changes `fsync` and `sdin` only together with the rising `sclk` edge, so they are steady whenever the port samples them on a falling edge. It also holds `en` steady during every frame it clocks, so the edge properties are never waived by a mid-bit disable.

// File: rtl/codec_link_port.sv
module codec_link_port #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                sclk,
  input  logic                fsync,
  input  logic                sdin,
  output logic                sdout,
  output logic                aux_lrclk,
  output logic                aux_sdo_a,
  output logic                aux_sdo_b,
  input  logic [2:0]          play_valid,
  input  logic [3*2*DW-1:0]   play_data,
  output logic [2:0]          play_ready,
  output logic [1:0]          cap_valid,
  output logic [2*2*DW-1:0]   cap_data,
  input  logic [1:0]          cap_ready,
  output logic [2:0]          underrun,
  output logic [1:0]          overrun
);
  localparam int FW    = 2 * DW;
  localparam int SLOT  = 2 * DW;
  localparam int FRAME = 2 * SLOT;
  localparam int PW    = $clog2(FRAME);
  localparam int AW    = $clog2(DEPTH);
  localparam int NF    = 5;
  localparam logic [PW-1:0] P_LAST  = PW'(FRAME - 1);
  localparam logic [PW-1:0] P_ADC_R = PW'(SLOT + DW - 1);
  localparam logic [PW-2:0] Q_ADC   = (PW-1)'(DW - 1);
  localparam logic [PW-2:0] Q_RET   = (PW-1)'(SLOT - 1);

  function automatic logic pri_bit(input logic [FW-1:0] w, input logic [PW-1:0] p);
    int q;
    int i;
    logic [FW-1:0] t;
    q = int'(p[PW-2:0]);
    if (q >= DW) return 1'b0;
    i = p[PW-1] ? (DW - 1 - q) : (FW - 1 - q);
    t = w >> i;
    return t[0];
  endfunction

  function automatic logic aux_bit(input logic [FW-1:0] w, input logic [PW-1:0] p);
    int q;
    int i;
    logic [FW-1:0] t;
    q = int'(p[PW-2:0]);
    if (q < DW) return 1'b0;
    i = p[PW-1] ? (FW - 1 - q) : (FW + DW - 1 - q);
    t = w >> i;
    return t[0];
  endfunction

  logic [2:0] sclk_p;
  logic [1:0] fs_p, din_p;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p <= '0;
      fs_p   <= '0;
      din_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      fs_p   <= {fs_p[0], fsync};
      din_p  <= {din_p[0], sdin};
    end
  end

  wire rise = sclk_p[1] & ~sclk_p[2];
  wire fall = ~sclk_p[1] & sclk_p[2];

  logic          fs_prev, locked;
  logic [PW-1:0] pos;
  wire           lock_now = en & ~locked & fall & fs_p[1] & ~fs_prev;
  wire           active   = en & (locked | lock_now);
  wire [PW-1:0]  pos_f    = lock_now ? '0 : pos;
  wire [PW-1:0]  pos_n    = pos + 1'b1;
  wire [PW-2:0]  q_f      = pos_f[PW-2:0];
  wire           ld_main  = en & locked & rise & (pos == P_LAST);
  wire           ld_aux   = active & fall & (pos_f == '0);
  wire [1:0]     cap_done = {active & fall & (pos_f == P_LAST),
                             active & fall & (pos_f == P_ADC_R)};

  logic [NF-1:0] f_push, f_pop, f_full, f_empty;
  logic [FW-1:0] f_wdata [NF];
  logic [FW-1:0] f_head  [NF];

  for (genvar g = 0; g < NF; g++) begin : g_fifo
    logic [FW-1:0] mem [DEPTH];
    logic [AW:0]   wp, rp;
    assign f_empty[g] = (wp == rp);
    assign f_full[g]  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign f_head[g]  = mem[rp[AW-1:0]];
    always_ff @(posedge clk)
      if (f_push[g]) mem[wp[AW-1:0]] <= f_wdata[g];
    always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (f_push[g]) wp <= wp + 1'b1;
        if (f_pop[g])  rp <= rp + 1'b1;
      end
    end
  end

  logic [DW-1:0] sh, adc_l, ret_l;
  wire  [DW-1:0] sh_n = {sh[DW-2:0], din_p[1]};

  always_comb begin
    for (int s = 0; s < 3; s++) begin
      f_wdata[s]    = play_data[s*FW +: FW];
      f_push[s]     = en & play_valid[s] & ~f_full[s];
      play_ready[s] = en & ~f_full[s];
    end
    f_pop[0]   = ld_main & ~f_empty[0];
    f_pop[1]   = ld_aux & ~f_empty[1];
    f_pop[2]   = ld_aux & ~f_empty[2];
    f_wdata[3] = {adc_l, sh_n};
    f_wdata[4] = {ret_l, sh_n};
    for (int c = 0; c < 2; c++) begin
      f_push[3+c]         = cap_done[c] & ~f_full[3+c];
      f_pop[3+c]          = ~f_empty[3+c] & cap_ready[c];
      cap_valid[c]        = ~f_empty[3+c];
      cap_data[c*FW +: FW] = f_head[3+c];
    end
  end

  logic [FW-1:0] main_w, aux_a_w, aux_b_w;
  wire  [FW-1:0] main_nx = f_empty[0] ? '0 : f_head[0];
  wire  [FW-1:0] a_nx    = f_empty[1] ? '0 : f_head[1];
  wire  [FW-1:0] b_nx    = f_empty[2] ? '0 : f_head[2];

  always_ff @(posedge clk) begin
    if (!rst_n) fs_prev <= 1'b1;
    else if (fall) fs_prev <= fs_p[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      locked    <= 1'b0;
      pos       <= '0;
      sdout     <= 1'b0;
      aux_lrclk <= 1'b0;
      aux_sdo_a <= 1'b0;
      aux_sdo_b <= 1'b0;
      main_w    <= '0;
      aux_a_w   <= '0;
      aux_b_w   <= '0;
      sh        <= '0;
      adc_l     <= '0;
      ret_l     <= '0;
      underrun  <= '0;
      overrun   <= '0;
    end else begin
      if (lock_now) begin
        locked <= 1'b1;
        pos    <= '0;
      end
      if (locked && rise) begin
        pos   <= pos_n;
        sdout <= pri_bit(ld_main ? main_nx : main_w, pos_n);
        if (ld_main) begin
          main_w <= main_nx;
          if (f_empty[0]) underrun[0] <= 1'b1;
        end
      end
      if (active && fall) begin
        aux_lrclk <= ~pos_f[PW-1];
        aux_sdo_a <= aux_bit(ld_aux ? a_nx : aux_a_w, pos_f);
        aux_sdo_b <= aux_bit(ld_aux ? b_nx : aux_b_w, pos_f);
        if (ld_aux) begin
          aux_a_w <= a_nx;
          aux_b_w <= b_nx;
          if (f_empty[1]) underrun[1] <= 1'b1;
          if (f_empty[2]) underrun[2] <= 1'b1;
        end
        sh <= sh_n;
        if (!pos_f[PW-1] && q_f == Q_ADC) adc_l <= sh_n;
        if (!pos_f[PW-1] && q_f == Q_RET) ret_l <= sh_n;
      end
      for (int c = 0; c < 2; c++)
        if (cap_done[c] && f_full[3+c]) overrun[c] <= 1'b1;
    end
  end
endmodule

// File: rtl/codec_link_port_chk.sv
module codec_link_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       sclk,
  input logic       sdout,
  input logic       aux_lrclk,
  input logic       aux_sdo_a,
  input logic       aux_sdo_b,
  input logic [2:0] underrun,
  input logic [1:0] overrun,
  input logic [1:0] cap_valid,
  input logic [1:0] cap_ready
);
  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sdout && !aux_lrclk && !aux_sdo_a && !aux_sdo_b &&
             underrun == '0 && overrun == '0 && cap_valid == '0));

  assert_sdout_rise_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sdout)) |-> sclk);

  assert_aux_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable({aux_lrclk, aux_sdo_a, aux_sdo_b})) |-> !sclk);

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((underrun & $past(underrun)) == $past(underrun)));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((overrun & $past(overrun)) == $past(overrun)));

  assert_cap_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_valid[0]) |-> ($past(cap_ready[0]) || !$past(en)));
endmodule

bind codec_link_port codec_link_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .sdout(sdout),
  .aux_lrclk(aux_lrclk), .aux_sdo_a(aux_sdo_a), .aux_sdo_b(aux_sdo_b),
  .underrun(underrun), .overrun(overrun),
  .cap_valid(cap_valid), .cap_ready(cap_ready)
);

// File: tb/codec_link_port_test.sv
module codec_link_port_test;
  localparam int DW = 16;
  localparam int FW = 2 * DW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en, sclk, fsync, sdin;
  logic sdout, aux_lrclk, aux_sdo_a, aux_sdo_b;
  logic [2:0] play_valid, play_ready, underrun;
  logic [3*FW-1:0] play_data;
  logic [1:0] cap_valid, cap_ready, overrun;
  logic [2*FW-1:0] cap_data;

  codec_link_port #(.DW(DW), .DEPTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .fsync(fsync), .sdin(sdin),
    .sdout(sdout), .aux_lrclk(aux_lrclk), .aux_sdo_a(aux_sdo_a), .aux_sdo_b(aux_sdo_b),
    .play_valid(play_valid), .play_data(play_data), .play_ready(play_ready),
    .cap_valid(cap_valid), .cap_data(cap_data), .cap_ready(cap_ready),
    .underrun(underrun), .overrun(overrun)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [FW-1:0] qp0[$], qp1[$], qp2[$], qa[$], qr[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pri_seq(input logic [FW-1:0] w);
    logic [63:0] s;
    for (int p = 0; p < 64; p++) begin
      logic [15:0] h;
      int q;
      q = p % 32;
      h = (p < 32) ? w[31:16] : w[15:0];
      s[p] = (q < 16) ? h[15-q] : 1'b0;
    end
    return s;
  endfunction

  function automatic logic [63:0] aux_seq(input logic [FW-1:0] w);
    logic [63:0] s;
    for (int p = 0; p < 64; p++) begin
      logic [15:0] h;
      int q;
      q = p % 32;
      h = (p < 32) ? w[31:16] : w[15:0];
      s[p] = (q >= 16) ? h[31-q] : 1'b0;
    end
    return s;
  endfunction

  task automatic push_play(input int s, input logic [FW-1:0] w);
    @(negedge clk);
    play_valid[s] = 1'b1;
    play_data[s*FW +: FW] = w;
    @(negedge clk);
    play_valid[s] = 1'b0;
    if (s == 0) qp0.push_back(w);
    else if (s == 1) qp1.push_back(w);
    else qp2.push_back(w);
  endtask

  task automatic run_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b1; fsync = 1'b0; sdin = 1'b1;
      repeat (8) @(negedge clk); sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic [FW-1:0] adc, input logic [FW-1:0] ret,
                           input bit prim_live, input bit aux_live, input bit cap_live);
    logic [63:0] so, sa, sb, lr;
    logic [FW-1:0] ep, ea, eb;
    for (int p = 0; p < 64; p++) begin
      logic [15:0] h;
      if ((p % 32) < 16) h = (p < 32) ? adc[31:16] : adc[15:0];
      else               h = (p < 32) ? ret[31:16] : ret[15:0];
      @(negedge clk); sclk = 1'b1; fsync = (p < 32); sdin = h[15 - (p % 16)];
      repeat (8) @(negedge clk); so[p] = sdout; sclk = 1'b0;
      repeat (8) @(negedge clk); sa[p] = aux_sdo_a; sb[p] = aux_sdo_b; lr[p] = aux_lrclk;
    end
    ep = (prim_live && qp0.size() > 0) ? qp0.pop_front() : '0;
    ea = (aux_live && qp1.size() > 0) ? qp1.pop_front() : '0;
    eb = (aux_live && qp2.size() > 0) ? qp2.pop_front() : '0;
    check(so == pri_seq(ep), "R3 R4 primary frame", so, pri_seq(ep));
    check(sa == aux_seq(ea), "R5 aux A frame", sa, aux_seq(ea));
    check(sb == aux_seq(eb), "R5 aux B frame", sb, aux_seq(eb));
    check(lr == (aux_live ? 64'h0000_0000_FFFF_FFFF : 64'h0), "R5 aux lrclk", lr,
          aux_live ? 64'h0000_0000_FFFF_FFFF : 64'h0);
    if (cap_live) begin
      if (qa.size() < 16) qa.push_back(adc);
      if (qr.size() < 16) qr.push_back(ret);
    end
  endtask

  task automatic read_cap(input int c, input int n);
    for (int i = 0; i < n; i++) begin
      logic [FW-1:0] e;
      @(negedge clk);
      e = (c == 0) ? qa.pop_front() : qr.pop_front();
      check(cap_valid[c] == 1'b1 && cap_data[c*FW +: FW] == e, "R6 capture pair",
            {31'd0, cap_valid[c], cap_data[c*FW +: FW]}, {32'd1, e});
      cap_ready[c] = 1'b1;
      @(negedge clk);
      cap_ready[c] = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 0; sclk = 0; fsync = 0; sdin = 0;
    play_valid = '0; play_data = '0; cap_ready = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({sdout, aux_lrclk, aux_sdo_a, aux_sdo_b} == 4'b0, "R1 reset outputs",
          {60'd0, sdout, aux_lrclk, aux_sdo_a, aux_sdo_b}, 64'd0);
    check(play_ready == 3'b000 && cap_valid == 2'b00, "R1 reset handshake",
          {59'd0, play_ready, cap_valid}, 64'd0);
    check(underrun == '0 && overrun == '0, "R1 reset flags", {59'd0, underrun, overrun}, 64'd0);

    // R1: a whole frame while disabled has no effect
    run_frame(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
    check(cap_valid == 2'b00, "R1 disabled capture", {62'd0, cap_valid}, 64'd0);

    en = 1;
    @(negedge clk);
    check(play_ready == 3'b111, "R9 ready after enable", {61'd0, play_ready}, 64'd7);
    push_play(0, 32'h8001_7FFE);
    push_play(0, 32'hA5A5_5A5A);
    push_play(0, 32'h1234_F00F);
    push_play(1, 32'hC003_0001);
    push_play(1, 32'h0FF0_8000);
    push_play(1, 32'hFFFF_0000);
    push_play(1, 32'h0000_FFFF);
    push_play(2, 32'h9ABC_DEF0);
    push_play(2, 32'h4321_8765);

    // R2: bits with fsync low do not align the port
    run_bits(20);
    check(cap_valid == 2'b00 && sdout == 1'b0, "R2 no alignment before fsync rise",
          {61'd0, cap_valid, sdout}, 64'd0);

    for (int f = 0; f < 6; f++) begin
      run_frame(32'hA5C3_0F00 + f * 32'h0101_1111, 32'h1234_FEDC ^ (f * 32'h0F0F_0303),
                f > 0, 1, 1);
      if (f == 1) check(underrun == 3'b000, "R7 no underrun yet", {61'd0, underrun}, 64'd0);
      if (f == 3) check(underrun == 3'b100, "R7 aux B underrun", {61'd0, underrun}, 64'd4);
      if (f == 5) check(underrun == 3'b111, "R7 all underrun", {61'd0, underrun}, 64'd7);
    end
    check(cap_valid == 2'b11, "R9 capture valid", {62'd0, cap_valid}, 64'd3);
    read_cap(0, 6);
    read_cap(1, 6);
    @(negedge clk);
    check(cap_valid == 2'b00, "R9 capture drained", {62'd0, cap_valid}, 64'd0);
    check(overrun == 2'b00, "R8 no overrun yet", {62'd0, overrun}, 64'd0);

    // R8: 18 frames into 16-deep capture FIFOs
    for (int f = 0; f < 18; f++)
      run_frame(32'h0F1E_2D3C ^ (f * 32'h1357_2468), 32'hF0E1_D2C3 + f * 32'h0003_0700, 1, 1, 1);
    check(overrun == 2'b11, "R8 overrun flagged", {62'd0, overrun}, 64'd3);
    read_cap(0, 16);
    read_cap(1, 16);
    @(negedge clk);
    check(cap_valid == 2'b00, "R8 only 16 pairs kept", {62'd0, cap_valid}, 64'd0);

    // R9: playback FIFO full
    for (int i = 0; i < 16; i++) push_play(0, 32'h0101_0101 * i);
    @(negedge clk);
    check(play_ready == 3'b110, "R9 ready low when full", {61'd0, play_ready}, 64'd6);

    en = 0;
    repeat (2) @(negedge clk);
    check(underrun == '0 && overrun == '0 && play_ready == '0 && sdout == 1'b0,
          "R1 disable clears", {57'd0, underrun, overrun, play_ready, sdout}, 64'd0);
    en = 1;
    @(negedge clk);
    check(play_ready == 3'b111, "R1 disable flushes FIFOs", {61'd0, play_ready}, 64'd7);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule